// File: doc/BRIEF.md
# System Control Byte Register with Fast CPU Reset

This block is a single byte-wide control register that sits on a simple I/O bus at address 0x92. Software uses it to open or close the A20 address gate, to fire a short, self-timed CPU reset pulse, to lock the CMOS/RTC security area, to drive an activity light, and to see whether a watchdog timeout has happened. Reads return the live state of every implemented bit.

The bits do not all behave the same way. The reset bit starts a pulse that ends by itself. It also stays readable across a CPU reset, so firmware can tell which reset path ran. The lock bit can only be set by software and only a power-on reset clears it. The watchdog bit is set by hardware and cleared by software.

The block has two reset inputs. Power-on reset clears everything. The separate CPU reset clears only the A20 gate and the activity bits, and it blocks bus writes while it is held.

Top module: `sys_ctrl_reg`

## Requirements
- R1: An access hits only when the address equals 0x92 and the size code is 2'b00 (one byte; 2'b01 and 2'b10 are wider). A write that misses changes no state. A read that misses returns 0x00.
- R2: A hit write with bit 0 = 0 sets the A20 gate output to bit 1 of the write. A hit read returns the gate state in bit 1.
- R3: A hit write with bit 0 = 1 drives the CPU reset output high for exactly PULSE_LEN clock cycles, starting in the cycle after the write. Another such write during the pulse restarts the count.
- R4: A hit write with bit 0 = 1 leaves the A20 gate, the lock, the activity bits and the watchdog bit unchanged.
- R5: Writing 1 to bit 3 sets the lock output. Writing 0 to bit 3 does not clear it. Only power-on reset clears it. The lock reads back in bit 3.
- R6: Bit 0 reads as 1 after a reset-pulse write. It is cleared by a hit write with bit 0 = 0 and by power-on reset. It is not cleared by CPU reset.
- R7: Bits 7 and 6 are stored and read back. The activity LED output is the OR of the two bits.
- R8: A one-cycle watchdog event sets bit 4. A hit write with bit 4 = 0 clears it. A write with bit 4 = 1 leaves it unchanged. If an event arrives in the same cycle as a clearing write, the event wins.
- R9: Bits 5 and 2 always read as 0, whatever was written to them.
- R10: After power-on reset, all outputs are low and the register reads 0x00.
- R11: While CPU reset is asserted (active low), the A20 gate and the activity bits are cleared and bus writes are ignored. The lock, bit 0 and bit 4 keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| cpuRstN | input | 1 | CPU reset, active low, synchronous |
| ioAddr | input | ADDR_W | I/O address |
| ioSize | input | 2 | Access size code; 2'b00 is one byte |
| ioWrEn | input | 1 | Write strobe |
| ioRdEn | input | 1 | Read strobe |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Read data; 0x00 when the access misses |
| wdEvent | input | 1 | One-cycle watchdog timeout event |
| a20Gate | output | 1 | A20 gate enable |
| cpuResetPulse | output | 1 | Fast alternate CPU reset pulse |
| cmosLock | output | 1 | CMOS/RTC security lock |
| activityLed | output | 1 | Activity light |

## Verification
The bench first runs directed write patterns, each built to separate one pair of bit meanings:
- A20-only values against values that also set bit 0, which shows that a reset write discards its other bits.
- Lock-set writes followed by lock-clear writes, which tells a sticky bit apart from a plain stored one.
- Watchdog events placed before, during and after clearing writes, which tests the set-wins priority.
- Wrong-address and wrong-size accesses, which must leave every output untouched.

A seeded random mix of addresses, sizes, data bytes, watchdog events and CPU reset windows then runs every bit interaction against a reference model. That model counts down the reset pulse independently, so restarted and overlapping pulses are checked cycle by cycle.

// File: rtl/sys_ctrl_pkg.sv
package sys_ctrl_pkg;
  localparam logic [1:0] SIZE_BYTE = 2'b00;

  typedef struct packed {
    logic wrApply;  // hit write with bit 0 clear: update stored bits
    logic wrReset;  // hit write with bit 0 set: start pulse, set flag
    logic rdHit;    // hit read
  } ioStrb_t;
endpackage

// File: rtl/sys_ctrl_ctl.sv
module sys_ctrl_ctl
  import sys_ctrl_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] REG_ADDR  = 16'h0092,
  parameter int          PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              cpuRstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        ioSize,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic              wrBit0,
  output ioStrb_t           strb,
  output logic              cpuResetPulse
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

  logic             addrHit;
  logic             wrHit;
  logic [CNT_W-1:0] pulseCnt;

  // An access hits only at the register address with a one-byte size.
  assign addrHit = (ioAddr == ADDR_W'(REG_ADDR)) && (ioSize == SIZE_BYTE);
  // Writes are accepted only while the CPU is out of reset.
  assign wrHit   = ioWrEn && addrHit && cpuRstN;

  always_comb begin
    strb.wrApply = wrHit && !wrBit0;
    strb.wrReset = wrHit && wrBit0;
    strb.rdHit   = ioRdEn && addrHit;
  end

  // Pulse counter: loaded on a reset write, counts down to zero.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)               pulseCnt <= '0;
    else if (strb.wrReset)      pulseCnt <= CNT_LOAD;
    else if (pulseCnt != '0)    pulseCnt <= pulseCnt - 1'b1;
  end

  assign cpuResetPulse = (pulseCnt != '0);

  // R3: the pulse is high in the cycle after a reset write.
  a_r3_pulse_start: assert property (@(posedge clk) disable iff (!porRstN)
    strb.wrReset |=> cpuResetPulse);
  // R3: the pulse ends once the count runs out, unless it is restarted.
  a_r3_pulse_end: assert property (@(posedge clk) disable iff (!porRstN)
    (pulseCnt == CNT_W'(1) && !strb.wrReset) |=> !cpuResetPulse);
  // R1: a wrong-size access produces no strobe.
  a_r1_size_reject: assert property (@(posedge clk) disable iff (!porRstN)
    (ioSize != SIZE_BYTE) |-> (strb == '0));
endmodule

// File: rtl/sys_ctrl_dp.sv
module sys_ctrl_dp
  import sys_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic       cpuRstN,
  input  ioStrb_t    strb,
  input  logic [7:0] ioWrData,
  input  logic       wdEvent,
  output logic [7:0] ioRdData,
  output logic       a20Gate,
  output logic       cmosLock,
  output logic       activityLed
);
  logic       a20Q;
  logic       lockQ;
  logic       rstFlagQ;
  logic       wdFlagQ;
  logic [1:0] actQ;

  // A20 gate and activity bits: cleared by CPU reset.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      a20Q <= 1'b0;
      actQ <= 2'b00;
    end else if (!cpuRstN) begin
      a20Q <= 1'b0;
      actQ <= 2'b00;
    end else if (strb.wrApply) begin
      a20Q <= ioWrData[1];
      actQ <= ioWrData[7:6];
    end
  end

  // Sticky lock: software can only set it.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                           lockQ <= 1'b0;
    else if (strb.wrApply && ioWrData[3])   lockQ <= 1'b1;
  end

  // Reset-method flag: survives CPU reset.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)           rstFlagQ <= 1'b0;
    else if (strb.wrReset)  rstFlagQ <= 1'b1;
    else if (strb.wrApply)  rstFlagQ <= 1'b0;
  end

  // Watchdog status: a hardware event takes priority over a software clear.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                            wdFlagQ <= 1'b0;
    else if (wdEvent)                        wdFlagQ <= 1'b1;
    else if (strb.wrApply && !ioWrData[4])   wdFlagQ <= 1'b0;
  end

  assign ioRdData    = strb.rdHit ? {actQ, 1'b0, wdFlagQ, lockQ, 1'b0, a20Q, rstFlagQ} : 8'h00;
  assign a20Gate     = a20Q;
  assign cmosLock    = lockQ;
  assign activityLed = |actQ;

  // R5: once set, the lock stays set until power-on reset.
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!porRstN)
    lockQ |=> lockQ);
  // R4, R1: the A20 gate moves only on an applied write or a CPU reset.
  a_r4_a20_hold: assert property (@(posedge clk) disable iff (!porRstN)
    (!strb.wrApply && cpuRstN) |=> $stable(a20Q));
  // R6, R11: the reset flag survives a CPU reset when there is no write.
  a_r6_flag_keep: assert property (@(posedge clk) disable iff (!porRstN)
    (!cpuRstN && rstFlagQ) |=> rstFlagQ);
  // R8: a watchdog event always leaves the flag set.
  a_r8_wd_set: assert property (@(posedge clk) disable iff (!porRstN)
    wdEvent |=> wdFlagQ);
  // R9: the unused bits always read as zero.
  always_comb begin
    a_r9_unused_zero: assert (ioRdData[5] == 1'b0 && ioRdData[2] == 1'b0);
  end
endmodule

// File: rtl/sys_ctrl_reg.sv
module sys_ctrl_reg
  import sys_ctrl_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] REG_ADDR  = 16'h0092,
  parameter int          PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              cpuRstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        ioSize,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  input  logic              wdEvent,
  output logic              a20Gate,
  output logic              cpuResetPulse,
  output logic              cmosLock,
  output logic              activityLed
);
  ioStrb_t strb;

  sys_ctrl_ctl #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .PULSE_LEN(PULSE_LEN)
  ) u_ctl (
    .clk          (clk),
    .porRstN      (porRstN),
    .cpuRstN      (cpuRstN),
    .ioAddr       (ioAddr),
    .ioSize       (ioSize),
    .ioWrEn       (ioWrEn),
    .ioRdEn       (ioRdEn),
    .wrBit0       (ioWrData[0]),
    .strb         (strb),
    .cpuResetPulse(cpuResetPulse)
  );

  sys_ctrl_dp u_dp (
    .clk        (clk),
    .porRstN    (porRstN),
    .cpuRstN    (cpuRstN),
    .strb       (strb),
    .ioWrData   (ioWrData),
    .wdEvent    (wdEvent),
    .ioRdData   (ioRdData),
    .a20Gate    (a20Gate),
    .cmosLock   (cmosLock),
    .activityLed(activityLed)
  );
endmodule

// File: tb/sys_ctrl_reg_tb.sv
`timescale 1ns/1ps
module sys_ctrl_reg_tb;
  localparam int PULSE_LEN = 4;
  localparam logic [15:0] RA = 16'h0092;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        cpuRstN = 1'b1;
  logic [15:0] ioAddr = '0;
  logic [1:0]  ioSize = '0;
  logic        ioWrEn = 1'b0;
  logic        ioRdEn = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic        wdEvent = 1'b0;
  logic        a20Gate, cpuResetPulse, cmosLock, activityLed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state
  bit       mA20, mLock, mFlag, mWd;
  bit [1:0] mAct;
  int       mCnt;

  always #2.5 clk = ~clk;

  sys_ctrl_reg #(.ADDR_W(16), .REG_ADDR(RA), .PULSE_LEN(PULSE_LEN)) u_dut (
    .clk(clk), .porRstN(porRstN), .cpuRstN(cpuRstN), .ioAddr(ioAddr), .ioSize(ioSize),
    .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .wdEvent(wdEvent), .a20Gate(a20Gate), .cpuResetPulse(cpuResetPulse),
    .cmosLock(cmosLock), .activityLed(activityLed)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [15:0] a, input logic [1:0] s);
    if (a == RA && s == 2'b00) return {mAct, 1'b0, mWd, mLock, 1'b0, mA20, mFlag};
    return 8'h00;
  endfunction

  task automatic clearModel();
    mA20 = 0; mLock = 0; mFlag = 0; mWd = 0; mAct = 0; mCnt = 0;
  endtask

  task automatic checkOutputs(input string tag);
    chk({tag, " a20"},   {7'd0, a20Gate},       {7'd0, mA20});
    chk({tag, " lock"},  {7'd0, cmosLock},      {7'd0, mLock});
    chk({tag, " led"},   {7'd0, activityLed},   {7'd0, |mAct});
    chk({tag, " pulse"}, {7'd0, cpuResetPulse}, {7'd0, (mCnt > 0)});
  endtask

  // One clock cycle: drive at the falling edge, update the model, check at the next falling edge.
  task automatic step(input bit wr, input logic [15:0] a, input logic [1:0] s,
                      input logic [7:0] d, input bit wd, input bit cpuR, input string tag);
    bit hit;
    ioWrEn = wr; ioAddr = a; ioSize = s; ioWrData = d; wdEvent = wd; cpuRstN = cpuR;
    hit = wr && a == RA && s == 2'b00 && cpuR;
    if (hit && d[0]) mCnt = PULSE_LEN;
    else if (mCnt > 0) mCnt--;
    if (!cpuR) begin
      mA20 = 0; mAct = 0;
    end else if (hit) begin
      if (d[0]) mFlag = 1;
      else begin
        mFlag = 0; mA20 = d[1]; mAct = d[7:6];
        if (d[3]) mLock = 1;
        if (!d[4]) mWd = 0;
      end
    end
    if (wd) mWd = 1;
    @(posedge clk);
    @(negedge clk);
    ioWrEn = 0; wdEvent = 0; cpuRstN = 1;
    checkOutputs(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 16'h0, 2'b00, 8'h00, 0, 1, tag);
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] s, input string tag);
    ioRdEn = 1; ioAddr = a; ioSize = s;
    #1;
    chk(tag, ioRdData, expRead(a, s));
    ioRdEn = 0;
  endtask

  task automatic doPor();
    @(negedge clk);
    porRstN = 0;
    clearModel();
    #1;
    checkOutputs("R10 por");
    rd(RA, 2'b00, "R10 por read");
    @(negedge clk);
    porRstN = 1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clearModel();
    doPor();
    idle(2, "R10 idle");

    // R2: A20 set and readback
    step(1, RA, 2'b00, 8'h02, 0, 1, "R2 a20 set");
    rd(RA, 2'b00, "R2 readback");
    // R1: wrong size, wrong address, miss read
    step(1, RA, 2'b01, 8'h00, 0, 1, "R1 word write ignored");
    step(1, RA, 2'b10, 8'hC8, 0, 1, "R1 dword write ignored");
    step(1, 16'h0093, 2'b00, 8'h00, 0, 1, "R1 addr ignored");
    rd(16'h0093, 2'b00, "R1 miss read");
    rd(RA, 2'b01, "R1 size miss read");
    // R3, R4, R6: reset write carrying other bits
    step(1, RA, 2'b00, 8'hD9, 0, 1, "R4 reset write");
    rd(RA, 2'b00, "R6 flag set");
    idle(2, "R3 pulse");
    step(1, RA, 2'b00, 8'h01, 0, 1, "R3 restart");
    idle(PULSE_LEN + 2, "R3 pulse end");
    // R11: CPU reset clears A20, keeps flag, ignores writes
    step(0, RA, 2'b00, 8'h00, 0, 0, "R11 cpu reset");
    step(1, RA, 2'b00, 8'hCA, 0, 0, "R11 write ignored");
    rd(RA, 2'b00, "R11 readback");
    // R5, R6: lock sticky, flag clear
    step(1, RA, 2'b00, 8'h08, 0, 1, "R5 lock set");
    step(1, RA, 2'b00, 8'h00, 0, 1, "R5 lock clear attempt");
    rd(RA, 2'b00, "R6 flag cleared");
    step(0, RA, 2'b00, 8'h00, 0, 0, "R11 lock kept");
    // R8: watchdog
    step(0, RA, 2'b00, 8'h00, 1, 1, "R8 event");
    rd(RA, 2'b00, "R8 set read");
    step(1, RA, 2'b00, 8'h10, 0, 1, "R8 write one");
    rd(RA, 2'b00, "R8 kept");
    step(1, RA, 2'b00, 8'h00, 1, 1, "R8 event wins");
    rd(RA, 2'b00, "R8 priority");
    step(1, RA, 2'b00, 8'h00, 0, 1, "R8 clear");
    rd(RA, 2'b00, "R8 cleared");
    // R7, R9
    step(1, RA, 2'b00, 8'h40, 0, 1, "R7 bit6");
    step(1, RA, 2'b00, 8'h80, 0, 1, "R7 bit7");
    rd(RA, 2'b00, "R7 readback");
    step(1, RA, 2'b00, 8'hC0, 0, 1, "R7 both");
    step(1, RA, 2'b00, 8'h24, 0, 1, "R9 unused write");
    rd(RA, 2'b00, "R9 readback");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [1:0]  s;
      logic [7:0]  d;
      int r;
      r = $urandom_range(0, 9);
      a = (r < 8) ? RA : 16'($urandom_range(0, 255));
      s = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 2)) : 2'b00;
      d = 8'($urandom);
      if ($urandom_range(0, 2) == 0) d[0] = 1'b0;
      step($urandom_range(0, 2) != 0, a, s, d, $urandom_range(0, 9) == 0,
           $urandom_range(0, 14) != 0, "R1-mix random");
      if ($urandom_range(0, 3) == 0) rd(a, s, "R2 R6 R7 R8 random read");
    end

    // R5, R10: power-on reset clears the lock
    step(1, RA, 2'b00, 8'h08, 0, 1, "R5 lock again");
    doPor();
    idle(1, "R10 after por");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule